// File: doc/BRIEF.md
# Test-and-Set Lock Requester with Exponential Backoff

This block is a hardware agent that takes and gives back a shared one-bit lock word. The lock word lives in a shared memory or arbiter and is reached through a test-and-set port. A lock word of 0 means the lock is open, and 1 means it is closed. When the agent is asked to acquire the lock, it sends a test-and-set. If the old value that comes back is 1, another owner holds the lock. The agent then waits a number of clock cycles and tries again. The wait doubles after every failed attempt, up to a configurable ceiling, which keeps traffic on the shared port low while the lock is contended. When the old value comes back as 0, this agent has closed the lock and reports that it holds it. A release request posts a store of 0 to the lock word.

The controller is a six-state machine:

| State | Role |
|---|---|
| IDLE | Waits for an acquire request. |
| TRY | Drives a one-cycle test-and-set request. |
| WAIT_RSP | Waits for the old value to return. |
| BACKOFF | Counts down the current retry delay. |
| HELD | The agent owns the lock. |
| RELEASE | Drives a one-cycle store of 0. |

Its transitions are:
- IDLE→TRY on an acquire request.
- TRY→WAIT_RSP always.
- WAIT_RSP→HELD when the response returns 0.
- WAIT_RSP→BACKOFF when the response returns 1.
- BACKOFF→TRY when the countdown expires.
- HELD→RELEASE on a release request.
- RELEASE→IDLE always.

Every other state holds its position. A failure counter records the failed attempts of the current acquisition so that they can be observed.

Top module: `spinlock_backoff_requester`

## Requirements
- R1: After reset the block is in IDLE: `mem_req`=0, `lock_held`=0 and `fail_count`=0.
- R2: An `acq_req` sampled in IDLE produces a test-and-set request (`mem_req`=1, `mem_tas`=1) in the following cycle.
- R3: A response with `mem_rsp_valid`=1 and `mem_rsp_old`=0 received while waiting raises `lock_held` in the next cycle.
- R4: A response with `mem_rsp_old`=1 received while waiting increments `fail_count` by one in the next cycle. The next test-and-set then appears exactly D+1 cycles after the response cycle, where D is the current delay.
- R5: D equals BASE_DELAY for the first failure of each acquisition and doubles after each later failure.
- R6: D never exceeds MAX_DELAY; once doubling would pass it, every later wait is MAX_DELAY cycles.
- R7: An `rel_req` sampled in HELD produces, in the next cycle, a single store request (`mem_req`=1, `mem_tas`=0) with `lock_held` already low. The block is back in IDLE after that cycle.
- R8: Requests outside their state are ignored. An `acq_req` outside IDLE causes no request and no change to `lock_held` or `fail_count`. An `rel_req` outside HELD causes no store.
- R9: `fail_count` is cleared when an acquire is accepted. It only steps by one and saturates at its maximum.
- R10: `mem_rsp_valid` outside WAIT_RSP has no effect on `lock_held`, `fail_count` or the request outputs.
- R11: `mem_req` is a one-cycle pulse and is never high while `lock_held` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | 1 | Request to take the lock |
| rel_req | input | 1 | Request to give the lock back |
| mem_req | output | 1 | One-cycle request to the lock port |
| mem_tas | output | 1 | 1: test-and-set, 0: store 0 (valid with `mem_req`) |
| mem_rsp_valid | input | 1 | Old value of a test-and-set is returned |
| mem_rsp_old | input | 1 | Old lock word value (0 open, 1 closed) |
| lock_held | output | 1 | The agent owns the lock |
| fail_count | output | CNT_W | Failed attempts of the current acquisition |

## Verification
The assertions rely on the lock port answering each test-and-set at most once, and no earlier than the cycle after the request. Stray response strobes are allowed in any state other than waiting. The bench's memory model replies with a random latency of two to five observation points after it sees a request, so the reply always lands in WAIT_RSP. It also injects random stray strobes, with random old values, only while no reply is outstanding. Contention is modelled by a second owner that holds the lock for a random number of failed attempts.

// File: rtl/slb_pkg.sv
package slb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRY,
        ST_WAIT_RSP,
        ST_BACKOFF,
        ST_HELD,
        ST_RELEASE
    } slb_state_e;

endpackage

// File: rtl/slb_fsm.sv
module slb_fsm
    import slb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic acq_req,
    input  logic rel_req,
    input  logic rsp_valid,
    input  logic rsp_old,
    input  logic backoff_done,
    output logic acq_accept,
    output logic fail_evt,
    output logic in_backoff,
    output logic mem_req,
    output logic mem_tas,
    output logic lock_held
);

    slb_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (acq_req) state_d = ST_TRY;
            ST_TRY:      state_d = ST_WAIT_RSP;
            ST_WAIT_RSP: if (rsp_valid) state_d = rsp_old ? ST_BACKOFF : ST_HELD;
            ST_BACKOFF:  if (backoff_done) state_d = ST_TRY;
            ST_HELD:     if (rel_req) state_d = ST_RELEASE;
            ST_RELEASE:  state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acq_accept = 1'b0;
        fail_evt   = 1'b0;
        in_backoff = 1'b0;
        mem_req    = 1'b0;
        mem_tas    = 1'b0;
        lock_held  = 1'b0;
        unique case (state_q)
            ST_IDLE:     acq_accept = acq_req;
            ST_TRY: begin
                mem_req = 1'b1;
                mem_tas = 1'b1;
            end
            ST_WAIT_RSP: fail_evt = rsp_valid & rsp_old;
            ST_BACKOFF:  in_backoff = 1'b1;
            ST_HELD:     lock_held = 1'b1;
            ST_RELEASE:  mem_req = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/slb_backoff.sv
module slb_backoff #(
    parameter int BASE_DELAY = 2,
    parameter int MAX_DELAY  = 32,
    localparam int DLY_W     = $clog2(MAX_DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             fail_evt,
    input  logic             in_backoff,
    output logic [DLY_W-1:0] cur_delay,
    output logic             done
);

    localparam logic [DLY_W-1:0] BASE_V = DLY_W'(BASE_DELAY);
    localparam logic [DLY_W:0]   MAX_W  = (DLY_W + 1)'(MAX_DELAY);

    logic [DLY_W-1:0] cnt_q;
    logic [DLY_W:0]   doubled;
    logic [DLY_W-1:0] next_delay;

    always_comb begin
        doubled    = {cur_delay, 1'b0};
        next_delay = (doubled > MAX_W) ? MAX_W[DLY_W-1:0] : doubled[DLY_W-1:0];
    end

    // delay for the next wait: base on a new acquisition, doubled per failure
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_delay <= BASE_V;
        end else if (restart) begin
            cur_delay <= BASE_V;
        end else if (fail_evt) begin
            cur_delay <= next_delay;
        end
    end

    // countdown of the active wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (fail_evt) begin
            cnt_q <= cur_delay;
        end else if (in_backoff && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = in_backoff && (cnt_q <= DLY_W'(1));

endmodule

// File: rtl/slb_fail_counter.sv
module slb_fail_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc && count != '1) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/spinlock_backoff_requester.sv
module spinlock_backoff_requester #(
    parameter int BASE_DELAY = 2,
    parameter int MAX_DELAY  = 32,
    parameter int CNT_W      = 8,
    localparam int DLY_W     = $clog2(MAX_DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_req,
    input  logic             rel_req,
    output logic             mem_req,
    output logic             mem_tas,
    input  logic             mem_rsp_valid,
    input  logic             mem_rsp_old,
    output logic             lock_held,
    output logic [CNT_W-1:0] fail_count
);

    logic             acq_accept;
    logic             fail_evt;
    logic             in_backoff;
    logic             backoff_done;
    logic [DLY_W-1:0] cur_delay;

    slb_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .acq_req      (acq_req),
        .rel_req      (rel_req),
        .rsp_valid    (mem_rsp_valid),
        .rsp_old      (mem_rsp_old),
        .backoff_done (backoff_done),
        .acq_accept   (acq_accept),
        .fail_evt     (fail_evt),
        .in_backoff   (in_backoff),
        .mem_req      (mem_req),
        .mem_tas      (mem_tas),
        .lock_held    (lock_held)
    );

    slb_backoff #(
        .BASE_DELAY (BASE_DELAY),
        .MAX_DELAY  (MAX_DELAY)
    ) backoff_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (acq_accept),
        .fail_evt   (fail_evt),
        .in_backoff (in_backoff),
        .cur_delay  (cur_delay),
        .done       (backoff_done)
    );

    slb_fail_counter #(
        .CNT_W (CNT_W)
    ) fails_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acq_accept),
        .inc   (fail_evt),
        .count (fail_count)
    );

endmodule

// File: rtl/slb_checker.sv
module slb_checker #(
    parameter int BASE_DELAY = 2,
    parameter int MAX_DELAY  = 32,
    parameter int CNT_W      = 8,
    localparam int DLY_W     = $clog2(MAX_DELAY + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rel_req,
    input logic             mem_req,
    input logic             mem_tas,
    input logic             mem_rsp_valid,
    input logic             mem_rsp_old,
    input logic             lock_held,
    input logic [CNT_W-1:0] fail_count,
    input logic [DLY_W-1:0] cur_delay
);

    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    a_r11_quiet_when_held: assert property (@(posedge clk) disable iff (!rst_n)
        lock_held |-> !mem_req);

    a_r7_store_follows_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_tas) |-> ($past(lock_held) && $past(rel_req)));

    a_r3_held_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_held) |-> ($past(mem_rsp_valid) && !$past(mem_rsp_old)));

    a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count != $past(fail_count)) |->
            (fail_count == CNT_W'($past(fail_count) + 1'b1) || fail_count == '0));

    a_r4_fail_needs_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_count != '0 && fail_count == CNT_W'($past(fail_count) + 1'b1)) |->
            ($past(mem_rsp_valid) && $past(mem_rsp_old)));

    a_r6_delay_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_delay >= DLY_W'(BASE_DELAY)) && (cur_delay <= DLY_W'(MAX_DELAY)));

endmodule

bind spinlock_backoff_requester slb_checker #(
    .BASE_DELAY (BASE_DELAY),
    .MAX_DELAY  (MAX_DELAY),
    .CNT_W      (CNT_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .rel_req       (rel_req),
    .mem_req       (mem_req),
    .mem_tas       (mem_tas),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_old   (mem_rsp_old),
    .lock_held     (lock_held),
    .fail_count    (fail_count),
    .cur_delay     (cur_delay)
);

// File: tb/spinlock_backoff_requester_tb.sv
module spinlock_backoff_requester_tb_top;

    localparam int BASE = 2;
    localparam int MAXD = 32;
    localparam int CW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acq_req = 1'b0;
    logic          rel_req = 1'b0;
    logic          mem_req;
    logic          mem_tas;
    logic          mem_rsp_valid = 1'b0;
    logic          mem_rsp_old = 1'b0;
    logic          lock_held;
    logic [CW-1:0] fail_count;

    int n_tests = 0;
    int n_fail  = 0;

    // memory / monitor model state
    int cyc = 0;
    bit lock_word = 1'b0;
    bit other_hold = 1'b0;
    bit spur_en = 1'b0;
    bit pending = 1'b0;
    bit pend_old = 1'b0;
    int lat_cnt = 0;
    bit fail_pending = 1'b0;
    int last_fail_cyc = 0;
    int succ_cyc = -10;
    int exp_delay = BASE;
    int model_fails = 0;
    bit held_prev = 1'b0;
    int n_tas = 0;
    int n_store = 0;

    always #5 clk = ~clk;

    spinlock_backoff_requester #(
        .BASE_DELAY (BASE),
        .MAX_DELAY  (MAXD),
        .CNT_W      (CW)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .acq_req       (acq_req),
        .rel_req       (rel_req),
        .mem_req       (mem_req),
        .mem_tas       (mem_tas),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_old   (mem_rsp_old),
        .lock_held     (lock_held),
        .fail_count    (fail_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic int next_delay(input int d);
        return (2 * d > MAXD) ? MAXD : 2 * d;
    endfunction

    // memory model and monitor: observe at the falling edge, then drive responses
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_req && mem_tas) begin
                n_tas++;
                check(!pending, "R11", 1, 0);
                if (fail_pending) begin
                    // R4/R5/R6: wait length from the failing response to the retry
                    check(cyc - last_fail_cyc == exp_delay + 1,
                          (exp_delay == MAXD) ? "R6" : "R5",
                          cyc - last_fail_cyc, exp_delay + 1);
                    exp_delay    = next_delay(exp_delay);
                    fail_pending = 1'b0;
                end else begin
                    exp_delay   = BASE;
                    model_fails = 0;
                end
                pend_old = lock_word | other_hold;
                if (!pend_old) lock_word = 1'b1;
                pending = 1'b1;
                lat_cnt = 2 + int'($urandom % 4);
            end
            if (mem_req && !mem_tas) begin
                n_store++;
                check(held_prev, "R7", 0, 1);
                lock_word = 1'b0;
            end
            if (mem_req) check(!lock_held, "R11", 1, 0);
            if (lock_held && !held_prev) check(cyc == succ_cyc + 1, "R3", cyc, succ_cyc + 1);
            check(int'(fail_count) == model_fails, "R4", int'(fail_count), model_fails);
            held_prev = lock_held;
        end
        mem_rsp_valid = 1'b0;
        mem_rsp_old   = 1'b0;
        if (rst_n && pending) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_old   = pend_old;
                pending       = 1'b0;
                if (pend_old) begin
                    fail_pending  = 1'b1;
                    last_fail_cyc = cyc;
                    model_fails   = model_fails + 1;
                end else begin
                    succ_cyc = cyc;
                end
            end
        end else if (rst_n && spur_en && ($urandom % 6 == 0)) begin
            // R10: stray strobes while nothing is outstanding
            mem_rsp_valid = 1'b1;
            mem_rsp_old   = 1'($urandom % 2);
        end
    end

    task automatic pulse_acq();
        @(negedge clk);
        acq_req = 1'b1;
        @(negedge clk);
        acq_req = 1'b0;
    endtask

    task automatic wait_held();
        int guard = 0;
        while (!lock_held && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(lock_held, "R3", 0, 1);
    endtask

    task automatic do_release();
        int st0;
        st0 = n_store;
        @(negedge clk);
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        check(mem_req && !mem_tas && !lock_held, "R7", {mem_req, mem_tas, lock_held}, 3'b100);
        @(negedge clk);
        check(!mem_req && !lock_held && n_store == st0 + 1, "R7", n_store - st0, 1);
    endtask

    task automatic contended_acquire(input int k, input bit rel_in_backoff);
        int guard;
        int st0;
        @(posedge clk);
        other_hold = (k > 0);
        pulse_acq();
        check(mem_req && mem_tas, "R2", {mem_req, mem_tas}, 2'b11);
        check(fail_count == '0, "R9", int'(fail_count), 0);
        if (k > 0) begin
            guard = 0;
            while (int'(fail_count) < k && guard < 5000) begin
                @(negedge clk);
                guard++;
            end
            if (rel_in_backoff) begin
                st0 = n_store;
                @(negedge clk);
                rel_req = 1'b1;
                @(negedge clk);
                rel_req = 1'b0;
                repeat (3) @(negedge clk);
                check(n_store == st0, "R8", n_store - st0, 0);
            end
            @(posedge clk);
            other_hold = 1'b0;
        end
        wait_held();
        @(negedge clk);
        check(int'(fail_count) == model_fails, "R9", int'(fail_count), model_fails);
    endtask

    initial begin
        int tas0;
        int st0;
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!mem_req && !lock_held && fail_count == '0, "R1",
              {mem_req, lock_held, fail_count != '0}, 0);

        // uncontended acquire and release
        contended_acquire(0, 1'b0);
        check(fail_count == '0, "R3", int'(fail_count), 0);

        // acquire request while held is ignored
        tas0 = n_tas;
        pulse_acq();
        repeat (4) @(negedge clk);
        check(lock_held && n_tas == tas0, "R8", n_tas - tas0, 0);
        do_release();

        // release request while idle is ignored
        st0 = n_store;
        @(negedge clk);
        rel_req = 1'b1;
        @(negedge clk);
        rel_req = 1'b0;
        repeat (4) @(negedge clk);
        check(n_store == st0 && !mem_req, "R8", n_store - st0, 0);

        // stray responses in idle and while held
        spur_en = 1'b1;
        repeat (20) @(negedge clk);
        check(!lock_held && fail_count == '0, "R10", int'(lock_held), 0);

        // directed: long contention reaching the ceiling
        contended_acquire(8, 1'b0);
        repeat (10) @(negedge clk);
        check(lock_held && int'(fail_count) == model_fails, "R10", int'(fail_count), model_fails);
        do_release();

        // random contention depths
        for (int it = 0; it < 12; it++) begin
            contended_acquire(int'($urandom % 10), (it % 3) == 1);
            repeat (int'($urandom % 5)) @(negedge clk);
            do_release();
            repeat (int'($urandom % 4)) @(negedge clk);
        end

        spur_en = 1'b0;
        repeat (10) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule